// File: doc/BRIEF.md
# Blocking Neighbour Channel Queue

This block connects one processor's memory-mapped bus to the point-to-point link of a neighbouring processor. It has two 32-bit queues. The outgoing queue is filled by bus writes and drained by the neighbour. The incoming queue is filled by the neighbour and drained by bus reads. The bus side is a slave that answers in the same cycle. When a blocking access cannot complete, the block withholds its acknowledge. The processor then sits in wait states until the queue state allows the transfer.

Software that must not stall can poll a status word instead. It can also use non-blocking accesses, which always complete at once. Two more paths support the processor. A supervisor-only read-back path lets the writer pull words out of its own outgoing queue, so the queue can be saved with a process context on a switch. An interrupt-pending input turns a stalled access into an error response and changes no queue state, so the access can be reissued after the trap handler returns.

Top module: `chanq_port`

## Requirements
- R1: A blocking read of the data register (address 0, non-blocking flag low) is held without acknowledge or error while the incoming queue is empty. Once a word is present, the read is acknowledged with the oldest word in the same cycle.
- R2: A blocking write to the data register is held without acknowledge or error while the outgoing queue is full. It is acknowledged and stored in the first cycle that the queue has space.
- R3: Each queue keeps first-in first-out order and holds DEPTH words. `rx_ready` is low exactly when the incoming queue is full. `tx_valid` presents the oldest outgoing word whenever that queue is non-empty, except during a read-back cycle (R6).
- R4: Address 1 is a read-only status word with these fields: bit 0 incoming empty, bit 1 incoming full, bit 2 outgoing empty, bit 3 outgoing full, bits 15:8 incoming count, bits 23:16 outgoing count. All other bits are zero.
- R5: A non-blocking read (flag high) of an empty incoming queue is acknowledged with data 0 and removes nothing. A non-blocking write to a full outgoing queue is acknowledged, the word is discarded, and the queue is unchanged.
- R6: In supervisor mode, a read of address 2 returns the oldest outgoing word and removes it from the queue. During that cycle `tx_valid` is low. On an empty queue the read returns 0 and removes nothing.
- R7: The following accesses get an error response with no acknowledge and leave both queues unchanged: a read of address 2 in user mode, any write to address 1 or 2, and any access to address 3.
- R8: While `irq_pend` is high, a stalled access is ended with an error and leaves both queues unchanged. A retry of the same access then behaves exactly like the first attempt.
- R9: When a queue is neither empty nor full, a push and a pop in the same cycle are both accepted and its count is unchanged.
- R10: After reset both queues are empty, the status word reads 0x00000005, `tx_valid` is low and `rx_ready` is high.
- R11: Acknowledge and error are never high together, and neither is high without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, held until acknowledge or error |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 read-back, 3 reserved |
| bus_nb | input | 1 | Non-blocking access flag |
| bus_sup | input | 1 | Processor is in supervisor mode |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Transfer acknowledge |
| bus_err | output | 1 | Error response |
| irq_pend | input | 1 | Interrupt pending; aborts a stalled access |
| tx_data | output | 32 | Oldest outgoing word |
| tx_valid | output | 1 | Outgoing word available |
| tx_ready | input | 1 | Neighbour takes the outgoing word |
| rx_data | input | 32 | Incoming word from neighbour |
| rx_valid | input | 1 | Neighbour offers a word |
| rx_ready | output | 1 | Incoming queue can accept a word |

## Verification
A wrong pointer or count shows up within one access. The word read or presented on `tx_data` is then out of order, or the status count disagrees with the number of words pushed and popped. A stall decision that is wrong in either direction appears in the same cycle as the request. Either an acknowledge comes back on an empty or full queue, or a held request never completes after the neighbour moves a word. Abort and privilege errors that wrongly touch a queue are caught by the next status read or by the next word drained.

// File: rtl/chanq_pkg.sv
package chanq_pkg;
  localparam int CHQ_DW = 32;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_RDBK = 2'd2,
    SEL_RSVD = 2'd3
  } sel_e;

  // Status word layout: flags in the low nibble, counts in two bytes above.
  function automatic logic [CHQ_DW-1:0] pack_status(
    input logic       in_e,
    input logic       in_f,
    input logic       out_e,
    input logic       out_f,
    input logic [7:0] in_c,
    input logic [7:0] out_c
  );
    return {8'd0, out_c, in_c, 4'd0, out_f, out_e, in_f, in_e};
  endfunction
endpackage

// File: rtl/chanq_fifo.sv
module chanq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/chanq_decode.sv
module chanq_decode
  import chanq_pkg::*;
(
  input  logic       req,
  input  logic       we,
  input  logic [1:0] sel,
  input  logic       nb,
  input  logic       sup,
  input  logic       in_empty,
  input  logic       out_full,
  input  logic       irq_pend,
  output logic       ack,
  output logic       err,
  output logic       rd_go,
  output logic       wr_go,
  output logic       rb_go,
  output logic       rb_sel
);
  sel_e s;
  logic illegal, stall;

  assign s       = sel_e'(sel);
  assign illegal = req && ((s == SEL_STAT && we) ||
                           (s == SEL_RDBK && (we || !sup)) ||
                           (s == SEL_RSVD));
  assign stall   = req && !illegal && (s == SEL_DATA) && !nb &&
                   (we ? out_full : in_empty);
  assign ack     = req && !illegal && !stall;
  assign err     = illegal || (stall && irq_pend);
  assign rd_go   = ack && !we && (s == SEL_DATA);
  assign wr_go   = ack && we && (s == SEL_DATA);
  assign rb_go   = ack && (s == SEL_RDBK);
  assign rb_sel  = req && !illegal && (s == SEL_RDBK);
endmodule

// File: rtl/chanq_port.sv
module chanq_port
  import chanq_pkg::*;
#(
  parameter int DEPTH = 16   // at most 255 so counts fit the status bytes
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic              bus_nb,
  input  logic              bus_sup,
  input  logic [CHQ_DW-1:0] bus_wdata,
  output logic [CHQ_DW-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  input  logic              irq_pend,
  output logic [CHQ_DW-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [CHQ_DW-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CHQ_DW-1:0] in_head, out_head;
  logic [CW-1:0]     in_cnt, out_cnt;
  logic [7:0]        in_cnt8, out_cnt8;
  logic              in_empty, in_full, out_empty, out_full;
  logic              rd_go, wr_go, rb_go, rb_sel;
  // Named internal events, also watched by the checker.
  logic              in_push, in_pop, out_push, out_pop, rb_pop, tx_fire;

  chanq_decode u_dec (
    .req(bus_req), .we(bus_we), .sel(bus_addr), .nb(bus_nb), .sup(bus_sup),
    .in_empty(in_empty), .out_full(out_full), .irq_pend(irq_pend),
    .ack(bus_ack), .err(bus_err), .rd_go(rd_go), .wr_go(wr_go),
    .rb_go(rb_go), .rb_sel(rb_sel)
  );

  assign rx_ready = !in_full;
  assign in_push  = rx_valid && !in_full;
  assign in_pop   = rd_go && !in_empty;
  assign out_push = wr_go && !out_full;
  assign rb_pop   = rb_go && !out_empty;
  assign tx_valid = !out_empty && !rb_sel;
  assign tx_fire  = tx_valid && tx_ready;
  assign out_pop  = rb_pop || tx_fire;
  assign tx_data  = out_head;
  assign in_cnt8  = 8'(in_cnt);
  assign out_cnt8 = 8'(out_cnt);

  chanq_fifo #(.W(CHQ_DW), .DEPTH(DEPTH)) u_inq (
    .clk(clk), .rst_n(rst_n), .push(in_push), .din(rx_data), .pop(in_pop),
    .dout(in_head), .count(in_cnt), .empty(in_empty), .full(in_full)
  );

  chanq_fifo #(.W(CHQ_DW), .DEPTH(DEPTH)) u_outq (
    .clk(clk), .rst_n(rst_n), .push(out_push), .din(bus_wdata), .pop(out_pop),
    .dout(out_head), .count(out_cnt), .empty(out_empty), .full(out_full)
  );

  always_comb begin
    case (sel_e'(bus_addr))
      SEL_DATA: bus_rdata = in_empty ? '0 : in_head;
      SEL_STAT: bus_rdata = pack_status(in_empty, in_full, out_empty, out_full,
                                        in_cnt8, out_cnt8);
      SEL_RDBK: bus_rdata = out_empty ? '0 : out_head;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/chanq_port_chk.sv
module chanq_port_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic       bus_nb,
  input logic       bus_ack,
  input logic       bus_err,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] in_cnt,
  input logic [7:0] out_cnt,
  input logic       in_push,
  input logic       in_pop,
  input logic       rb_pop
);
  assert_ack_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (!bus_ack && !bus_err));

  assert_rd_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == 2'd0 && !bus_nb && in_cnt == 8'd0) |-> !bus_ack);

  assert_wr_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == 2'd0 && !bus_nb && out_cnt == 8'(DEPTH)) |-> !bus_ack);

  assert_rx_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == 8'(DEPTH)) |-> !rx_ready);

  assert_in_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !(rx_valid && rx_ready)) |=> (in_cnt == $past(in_cnt)));

  assert_out_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !(tx_valid && tx_ready)) |=> (out_cnt == $past(out_cnt)));

  assert_both_ways_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && in_pop) |=> (in_cnt == $past(in_cnt)));

  assert_rb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_pop |-> !tx_valid);
endmodule

bind chanq_port chanq_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_nb(bus_nb), .bus_ack(bus_ack), .bus_err(bus_err),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .in_cnt(in_cnt8), .out_cnt(out_cnt8),
  .in_push(in_push), .in_pop(in_pop), .rb_pop(rb_pop)
);

// File: tb/chanq_port_tb.sv
`timescale 1ns/1ps
module chanq_port_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_nb = 1'b0, bus_sup = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err;
  logic        irq_pend = 1'b0;
  logic [31:0] tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  chanq_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_nb(bus_nb), .bus_sup(bus_sup),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .irq_pend(irq_pend), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // Expected status word, built from the field list of R4.
  function automatic logic [31:0] st(input int ic, input int oc);
    logic [31:0] v;
    v = '0;
    v[0] = (ic == 0); v[1] = (ic == DEPTH);
    v[2] = (oc == 0); v[3] = (oc == DEPTH);
    v[15:8]  = ic[7:0];
    v[23:16] = oc[7:0];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // One bus access: drive at negedge, sample 1 ns later, drop after the edge.
  task automatic do_op(input logic we, input logic [1:0] a, input logic nb, input logic sup,
                       input logic [31:0] wd, output logic ack, output logic err,
                       output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_nb = nb; bus_sup = sup; bus_wdata = wd;
    #1;
    ack = bus_ack; err = bus_err; rd = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic status_is(input logic [31:0] exp, input string tag);
    logic a, e; logic [31:0] r;
    do_op(1'b0, 2'd1, 1'b0, 1'b0, '0, a, e, r);
    chk(a && !e && r == exp, tag, r, exp);
  endtask

  // {we, addr, nb, sup, wdata, exp_ack, exp_err, exp_rdata}
  localparam logic [70:0] TBL [12] = '{
    {1'b1, 2'd0, 1'b0, 1'b0, 32'h000000A1, 1'b1, 1'b0, 32'h0},        // R2 write
    {1'b1, 2'd0, 1'b0, 1'b0, 32'h000000A2, 1'b1, 1'b0, 32'h0},        // R2 write
    {1'b0, 2'd1, 1'b0, 1'b0, 32'h0,        1'b1, 1'b0, 32'h00020001}, // R4 status
    {1'b0, 2'd2, 1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 32'h0},        // R7 user read-back
    {1'b1, 2'd1, 1'b0, 1'b1, 32'h0,        1'b0, 1'b1, 32'h0},        // R7 status write
    {1'b0, 2'd3, 1'b0, 1'b1, 32'h0,        1'b0, 1'b1, 32'h0},        // R7 reserved
    {1'b0, 2'd2, 1'b0, 1'b1, 32'h0,        1'b1, 1'b0, 32'h000000A1}, // R6 read-back
    {1'b0, 2'd0, 1'b1, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0},        // R5 nb read empty
    {1'b0, 2'd1, 1'b0, 1'b0, 32'h0,        1'b1, 1'b0, 32'h00010001}, // R4 status
    {1'b0, 2'd2, 1'b0, 1'b1, 32'h0,        1'b1, 1'b0, 32'h000000A2}, // R6 read-back
    {1'b0, 2'd2, 1'b0, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0},        // R6 empty read-back
    {1'b0, 2'd1, 1'b0, 1'b0, 32'h0,        1'b1, 1'b0, 32'h00000005}  // R4 status
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic a, e; logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R10 reset state, R11 quiet bus
    chk(!tx_valid, "R10 tx_valid", 32'(tx_valid), 32'h0);
    chk(rx_ready, "R10 rx_ready", 32'(rx_ready), 32'h1);
    chk(!bus_ack && !bus_err, "R11 idle response", {bus_ack, bus_err}, 32'h0);
    status_is(32'h00000005, "R10 status");

    // Vector table
    for (int i = 0; i < 12; i++) begin
      logic [70:0] v;
      v = TBL[i];
      do_op(v[70], v[69:68], v[67], v[66], v[65:34], a, e, r);
      chk(a == v[33] && e == v[32], $sformatf("R7 table %0d response", i), {a, e}, {v[33], v[32]});
      if (v[33] && !v[70])
        chk(r == v[31:0], $sformatf("R4 table %0d rdata", i), r, v[31:0]);
    end

    // R3 incoming order
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 32'hB0 + i;
    end
    @(negedge clk) rx_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      do_op(1'b0, 2'd0, 1'b0, 1'b0, '0, a, e, r);
      chk(a && r == 32'hB0 + i, "R3 incoming order", r, 32'hB0 + i);
    end

    // R3 outgoing order
    for (int i = 0; i < 3; i++) do_op(1'b1, 2'd0, 1'b0, 1'b0, 32'hC0 + i, a, e, r);
    @(negedge clk) tx_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(tx_valid && tx_data == 32'hC0 + i, "R3 outgoing order", tx_data, 32'hC0 + i);
      @(negedge clk);
    end
    #1 chk(!tx_valid, "R3 tx_valid empty", 32'(tx_valid), 32'h0);
    tx_ready = 1'b0;

    // R3 fill incoming queue
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 32'hD00 + i;
    end
    @(negedge clk); rx_data = 32'hDEAD;
    #1 chk(!rx_ready, "R3 rx_ready when full", 32'(rx_ready), 32'h0);
    @(negedge clk) rx_valid = 1'b0;
    status_is(st(DEPTH, 0), "R4 incoming full status");

    // R9 simultaneous push and pop
    do_op(1'b0, 2'd0, 1'b0, 1'b0, '0, a, e, r);
    chk(a && r == 32'hD00, "R3 first of full", r, 32'hD00);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 32'hE0;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; bus_nb = 1'b0; bus_sup = 1'b0;
    #1 chk(bus_ack && rx_ready && bus_rdata == 32'hD01, "R9 both accepted", bus_rdata, 32'hD01);
    @(negedge clk); rx_valid = 1'b0; bus_req = 1'b0;
    status_is(st(DEPTH-1, 0), "R9 count unchanged");
    for (int i = 2; i < DEPTH; i++) begin
      do_op(1'b0, 2'd0, 1'b0, 1'b0, '0, a, e, r);
      chk(a && r == 32'hD00 + i, "R3 drain order", r, 32'hD00 + i);
    end
    do_op(1'b0, 2'd0, 1'b0, 1'b0, '0, a, e, r);
    chk(a && r == 32'hE0, "R9 pushed word last", r, 32'hE0);

    // R1 blocking read stall then release
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; bus_nb = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 chk(!bus_ack && !bus_err, "R1 held while empty", {bus_ack, bus_err}, 32'h0);
      @(negedge clk);
    end
    rx_valid = 1'b1; rx_data = 32'hF1;
    #1 chk(!bus_ack, "R1 held same cycle", 32'(bus_ack), 32'h0);
    @(negedge clk) rx_valid = 1'b0;
    #1 chk(bus_ack && bus_rdata == 32'hF1, "R1 completes", bus_rdata, 32'hF1);
    @(negedge clk) bus_req = 1'b0;

    // R8 abort of stalled read, then retry
    irq_pend = 1'b1;
    do_op(1'b0, 2'd0, 1'b0, 1'b0, '0, a, e, r);
    chk(e && !a, "R8 read aborted", {a, e}, 32'h1);
    irq_pend = 1'b0;
    status_is(st(0, 0), "R8 state after abort");
    do_op(1'b0, 2'd0, 1'b0, 1'b0, '0, a, e, r);
    chk(!a && !e, "R8 retry stalls again", {a, e}, 32'h0);

    // R2 fill outgoing, R5 nb write full, R8 write abort
    for (int i = 0; i < DEPTH; i++) do_op(1'b1, 2'd0, 1'b0, 1'b0, 32'h100 + i, a, e, r);
    status_is(st(0, DEPTH), "R4 outgoing full status");
    do_op(1'b1, 2'd0, 1'b1, 1'b0, 32'h999, a, e, r);
    chk(a && !e, "R5 nb write full acked", {a, e}, 32'h2);
    status_is(st(0, DEPTH), "R5 queue unchanged");
    irq_pend = 1'b1;
    do_op(1'b1, 2'd0, 1'b0, 1'b0, 32'h777, a, e, r);
    chk(e && !a, "R8 write aborted", {a, e}, 32'h1);
    irq_pend = 1'b0;
    status_is(st(0, DEPTH), "R8 outgoing unchanged");

    // R2 blocking write waits for space
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_nb = 1'b0; bus_wdata = 32'h200;
    #1 chk(!bus_ack && !bus_err, "R2 held while full", {bus_ack, bus_err}, 32'h0);
    @(negedge clk) tx_ready = 1'b1;
    #1 chk(!bus_ack, "R2 held until space", 32'(bus_ack), 32'h0);
    @(negedge clk) tx_ready = 1'b0;
    #1 chk(bus_ack, "R2 completes", 32'(bus_ack), 32'h1);
    @(negedge clk) bus_req = 1'b0;

    // R6 read-back blocks tx and drains in order
    @(negedge clk);
    tx_ready = 1'b1;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 2'd2; bus_sup = 1'b1;
    #1 chk(!tx_valid && bus_ack && bus_rdata == 32'h101, "R6 read-back head", bus_rdata, 32'h101);
    @(negedge clk); tx_ready = 1'b0; bus_req = 1'b0;
    for (int i = 2; i < DEPTH; i++) begin
      do_op(1'b0, 2'd2, 1'b0, 1'b1, '0, a, e, r);
      chk(a && r == 32'h100 + i, "R6 read-back order", r, 32'h100 + i);
    end
    do_op(1'b0, 2'd2, 1'b0, 1'b1, '0, a, e, r);
    chk(a && r == 32'h200, "R5 dropped word absent", r, 32'h200);
    do_op(1'b0, 2'd2, 1'b0, 1'b1, '0, a, e, r);
    chk(a && r == 32'h0, "R6 empty read-back", r, 32'h0);
    status_is(32'h00000005, "R6 all drained");

    finish_run();
  end
endmodule